// File: doc/BRIEF.md
# I2C Port-Expander Pin Shadow Controller

This block keeps a local copy of the output bytes of an I2C port expander. The host works one pin at a time. It can drive a pin high or low, or ask for the last value it wrote. A pin is named by a small index: the high part picks the port byte and the low three bits pick the bit inside that byte. A drive command changes the local byte in the same clock edge that accepts the command. The block then hands the whole new byte to an I2C master engine as a one-byte write. The write goes to a device address formed from a fixed base and the port number.

Queries are answered combinationally from the local copy and never start bus traffic. While a write is in flight, the block refuses new drive commands. When the engine reports completion, the block returns a one-cycle response that carries the engine's no-acknowledge flag as an error for that command.

Top module: `pexp_shadow_ctrl`

## Requirements
- R1: After reset, every bit of every port byte reads 1 (each byte is 0xFF), `cmd_ready` is 1, and `mst_req` and `rsp_valid` are 0.
- R2: Pin index bit 3 selects the port byte (0 or 1), and index bits 2:0 select the bit within it (0 = least significant).
- R3: A drive command with `cmd_op`=1 (set) makes the selected bit 1 and leaves every other bit of both bytes unchanged.
- R4: A drive command with `cmd_op`=0 (clear) makes the selected bit 0 and leaves every other bit of both bytes unchanged.
- R5: A command is accepted at a rising edge where `cmd_valid` and `cmd_ready` are both 1. The query output shows the old bit before that edge and the new bit right after it.
- R6: From the cycle after acceptance, `mst_req` is 1. It stays 1 with `mst_addr` and `mst_data` stable until an edge where `mst_done` is 1. `mst_addr` is 0x40 for port 0 and 0x42 for port 1, and `mst_data` is the full updated byte of that port.
- R7: From acceptance until the edge where `mst_done` is sampled, `cmd_ready` is 0. A `cmd_valid` asserted during that interval changes no bit and starts no write.
- R8: In the cycle after the edge where `mst_done` is sampled, `rsp_valid` is 1 for exactly one cycle. `rsp_err` equals the `mst_nack` value sampled with `mst_done`, and `mst_req` is 0.
- R9: `qry_val` is a combinational function of `qry_pin` and the stored bytes. Queries never raise `mst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Drive command present |
| cmd_op | input | 1 | 1 = set pin, 0 = clear pin |
| cmd_pin | input | 4 | Pin index of the drive command |
| cmd_ready | output | 1 | Block can accept a drive command |
| qry_pin | input | 4 | Pin index to query |
| qry_val | output | 1 | Stored value of the queried pin |
| mst_req | output | 1 | Write request to the I2C master engine |
| mst_addr | output | 8 | Device address byte (write direction, LSB 0) |
| mst_data | output | 8 | Data byte to write |
| mst_done | input | 1 | Engine finished the current write |
| mst_nack | input | 1 | Engine saw no acknowledge (valid with mst_done) |
| rsp_valid | output | 1 | One-cycle completion of a drive command |
| rsp_err | output | 1 | Completed command saw no acknowledge |

## Verification
A query and a drive command that target the same pin can fall in the same cycle. The bench points `qry_pin` at the commanded pin while `cmd_valid` is high. It expects the old bit before the accepting edge and the new bit right after it. The second collision is a stray drive command raised while a write is in flight. It must be refused, and this is judged by checking that the pin it targeted still holds the model value and that `mst_addr`/`mst_data` stay unchanged.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_WAIT = 1'b1
   } seq_state_t;

   typedef enum logic {
      OP_CLEAR = 1'b0,
      OP_SET   = 1'b1
   } pin_op_t;

   localparam int unsigned BIT_IDX_W = 3;
   localparam int unsigned BYTE_W    = 8;

   // device address: base with port number placed above the direction bit
   function automatic logic [BYTE_W-1:0] dev_addr(input logic [BYTE_W-1:0] base,
                                                  input int unsigned port);
      return base | BYTE_W'(port << 1);
   endfunction

endpackage

// File: rtl/pexp_shadow_bank.sv
module pexp_shadow_bank
   import pexp_pkg::*;
#(
   parameter int unsigned     PORTS     = 2,
   parameter logic [7:0]      RESET_VAL = 8'hFF,
   localparam int unsigned    PORT_W    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     wr_set,
   input  logic [PORT_W-1:0]        wr_port,
   input  logic [BIT_IDX_W-1:0]     wr_bit,
   input  logic [PORT_W-1:0]        rd_port,
   input  logic [BIT_IDX_W-1:0]     rd_bit,
   output logic                     rd_val,
   input  logic [PORT_W-1:0]        sel_port,
   output logic [BYTE_W-1:0]        sel_byte,
   output logic [PORTS*BYTE_W-1:0]  shadow_flat
);

   logic [BYTE_W-1:0] shadow_q [PORTS];
   logic [BYTE_W-1:0] bit_mask;

   assign bit_mask = BYTE_W'(1) << wr_bit;

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_q[p] <= RESET_VAL;
         end else if (wr_en && (wr_port == PORT_W'(p))) begin
            if (wr_set) shadow_q[p] <= shadow_q[p] | bit_mask;
            else        shadow_q[p] <= shadow_q[p] & ~bit_mask;
         end
      end
      assign shadow_flat[p*BYTE_W +: BYTE_W] = shadow_q[p];
   end

   assign rd_val   = shadow_q[rd_port][rd_bit];
   assign sel_byte = shadow_q[sel_port];

endmodule

// File: rtl/pexp_write_seq.sv
module pexp_write_seq
   import pexp_pkg::*;
#(
   parameter int unsigned  PORT_W    = 1,
   parameter logic [7:0]   ADDR_BASE = 8'h40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [PORT_W-1:0]  cmd_port,
   output logic               cmd_ready,
   output logic               accept,
   output logic [PORT_W-1:0]  lat_port,
   input  logic [BYTE_W-1:0]  sel_byte,
   output logic               mst_req,
   output logic [BYTE_W-1:0]  mst_addr,
   output logic [BYTE_W-1:0]  mst_data,
   input  logic               mst_done,
   input  logic               mst_nack,
   output logic               rsp_valid,
   output logic               rsp_err
);

   seq_state_t state_q;
   logic       finish;

   assign cmd_ready = (state_q == SEQ_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign finish    = (state_q == SEQ_WAIT) && mst_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         lat_port  <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= finish;
         if (finish) rsp_err <= mst_nack;
         if (accept) begin
            state_q  <= SEQ_WAIT;
            lat_port <= cmd_port;
         end else if (finish) begin
            state_q  <= SEQ_IDLE;
         end
      end
   end

   // the stored byte cannot change while waiting, so it is driven straight out
   assign mst_req  = (state_q == SEQ_WAIT);
   assign mst_addr = dev_addr(ADDR_BASE, int'(lat_port));
   assign mst_data = sel_byte;

endmodule

// File: rtl/pexp_shadow_ctrl.sv
module pexp_shadow_ctrl
   import pexp_pkg::*;
#(
   parameter int unsigned  PORTS     = 2,
   parameter int unsigned  PIN_W     = 4,
   parameter logic [7:0]   ADDR_BASE = 8'h40,
   parameter logic [7:0]   RESET_VAL = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_op,
   input  logic [PIN_W-1:0]  cmd_pin,
   output logic              cmd_ready,
   input  logic [PIN_W-1:0]  qry_pin,
   output logic              qry_val,
   output logic              mst_req,
   output logic [7:0]        mst_addr,
   output logic [7:0]        mst_data,
   input  logic              mst_done,
   input  logic              mst_nack,
   output logic              rsp_valid,
   output logic              rsp_err
);

   localparam int unsigned PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1;

   if (PORTS < 2 || (PORTS & (PORTS - 1)) != 0) begin : g_bad_ports
      $error("PORTS must be a power of two, at least 2");
   end
   if (PIN_W != BIT_IDX_W + PORT_W) begin : g_bad_pin_w
      $error("PIN_W must equal 3 + log2(PORTS)");
   end
   if (ADDR_BASE[PORT_W:0] != '0) begin : g_bad_base
      $error("ADDR_BASE low bits must be free for port and direction");
   end

   logic              accept;
   logic [PORT_W-1:0] lat_port;
   logic [7:0]        sel_byte;
   logic [PORTS*8-1:0] shadow_flat;

   pexp_shadow_bank #(
      .PORTS     (PORTS),
      .RESET_VAL (RESET_VAL)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (accept),
      .wr_set      (cmd_op == OP_SET),
      .wr_port     (cmd_pin[PIN_W-1:BIT_IDX_W]),
      .wr_bit      (cmd_pin[BIT_IDX_W-1:0]),
      .rd_port     (qry_pin[PIN_W-1:BIT_IDX_W]),
      .rd_bit      (qry_pin[BIT_IDX_W-1:0]),
      .rd_val      (qry_val),
      .sel_port    (lat_port),
      .sel_byte    (sel_byte),
      .shadow_flat (shadow_flat)
   );

   pexp_write_seq #(
      .PORT_W    (PORT_W),
      .ADDR_BASE (ADDR_BASE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_port  (cmd_pin[PIN_W-1:BIT_IDX_W]),
      .cmd_ready (cmd_ready),
      .accept    (accept),
      .lat_port  (lat_port),
      .sel_byte  (sel_byte),
      .mst_req   (mst_req),
      .mst_addr  (mst_addr),
      .mst_data  (mst_data),
      .mst_done  (mst_done),
      .mst_nack  (mst_nack),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err)
   );

endmodule

// File: rtl/pexp_shadow_chk.sv
module pexp_shadow_chk #(
   parameter int unsigned  PORTS     = 2,
   parameter logic [7:0]   ADDR_BASE = 8'h40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              mst_req,
   input logic [7:0]        mst_addr,
   input logic [7:0]        mst_data,
   input logic              mst_done,
   input logic              mst_nack,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [PORTS*8-1:0] shadow_flat
);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_req && !mst_done) |=> (mst_req && $stable(mst_addr) && $stable(mst_data))); // R6

   AST_ADDR_WRITE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      mst_req |-> (mst_addr[0] == 1'b0 && mst_addr[7:2] == ADDR_BASE[7:2])); // R6

   AST_REQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mst_req) |-> $past(cmd_valid && cmd_ready)); // R9

   AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_ready && mst_req)); // R7

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_ready) |=> $stable(shadow_flat)); // R7

   AST_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(mst_req && mst_done)); // R8

   AST_RSP_ERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_err == $past(mst_nack))); // R8

   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mst_req); // R8

endmodule

bind pexp_shadow_ctrl pexp_shadow_chk #(
   .PORTS     (PORTS),
   .ADDR_BASE (ADDR_BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_ready   (cmd_ready),
   .mst_req     (mst_req),
   .mst_addr    (mst_addr),
   .mst_data    (mst_data),
   .mst_done    (mst_done),
   .mst_nack    (mst_nack),
   .rsp_valid   (rsp_valid),
   .rsp_err     (rsp_err),
   .shadow_flat (shadow_flat)
);

// File: tb/pexp_shadow_ctrl_test.sv
module pexp_shadow_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cmd_valid, cmd_op;
   logic [3:0] cmd_pin, qry_pin;
   logic       cmd_ready, qry_val;
   logic       mst_req, mst_done, mst_nack;
   logic [7:0] mst_addr, mst_data;
   logic       rsp_valid, rsp_err;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] model [2];

   always #4 clk = ~clk;

   pexp_shadow_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pin(cmd_pin), .cmd_ready(cmd_ready),
      .qry_pin(qry_pin), .qry_val(qry_val),
      .mst_req(mst_req), .mst_addr(mst_addr), .mst_data(mst_data),
      .mst_done(mst_done), .mst_nack(mst_nack),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err)
   );

   function automatic logic [7:0] exp_addr(input logic [3:0] pin);
      return 8'h40 | {6'd0, pin[3], 1'b0};          // R6
   endfunction

   function automatic logic exp_bit(input logic [3:0] pin);
      return model[pin[3]][pin[2:0]];               // R2
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic sweep();
      for (int p = 0; p < 16; p++) begin
         @(negedge clk);
         qry_pin = 4'(p);
         #1;
         chk("R2/R9 query", {31'd0, qry_val}, {31'd0, exp_bit(4'(p))});
         chk("R9 no traffic", {31'd0, mst_req}, 0);
      end
   endtask

   task automatic drive(input logic op, input logic [3:0] pin, input logic nack,
                        input int lat, input bit stray);
      logic [7:0] a0, d0;
      logic [3:0] spin;
      int wait_n = 0;
      spin = 4'($urandom_range(0, 15));
      @(negedge clk);
      while (!cmd_ready && wait_n < 100) begin @(negedge clk); wait_n++; end
      if (wait_n >= 100) chk("R7 ready timeout", 0, 1);
      cmd_valid = 1'b1; cmd_op = op; cmd_pin = pin; qry_pin = pin;
      #1;
      chk("R5 old value before edge", {31'd0, qry_val}, {31'd0, exp_bit(pin)});
      if (op) model[pin[3]][pin[2:0]] = 1'b1;      // R3
      else    model[pin[3]][pin[2:0]] = 1'b0;      // R4
      @(negedge clk);
      cmd_valid = 1'b0;
      #1;
      chk(op ? "R3 set bit" : "R4 clear bit", {31'd0, qry_val}, {31'd0, exp_bit(pin)});
      chk("R6 req", {31'd0, mst_req}, 1);
      chk("R7 ready low", {31'd0, cmd_ready}, 0);
      chk("R6 addr", {24'd0, mst_addr}, {24'd0, exp_addr(pin)});
      chk("R6 data", {24'd0, mst_data}, {24'd0, model[pin[3]]});
      a0 = mst_addr; d0 = mst_data;
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         cmd_valid = (stray && i == 0);
         cmd_op = $urandom_range(0, 1) != 0; cmd_pin = spin;
         #1;
         chk("R6 hold req", {31'd0, mst_req}, 1);
         chk("R6 hold addr/data", {16'd0, mst_addr, mst_data}, {16'd0, a0, d0});
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      mst_done = 1'b1; mst_nack = nack;
      @(negedge clk);
      mst_done = 1'b0; mst_nack = 1'b0;
      qry_pin = spin;
      #1;
      chk("R8 rsp_valid", {31'd0, rsp_valid}, 1);
      chk("R8 rsp_err", {31'd0, rsp_err}, {31'd0, nack});
      chk("R8 req dropped", {31'd0, mst_req}, 0);
      chk("R7 ready back", {31'd0, cmd_ready}, 1);
      chk("R7 stray ignored", {31'd0, qry_val}, {31'd0, exp_bit(spin)});
      @(negedge clk);
      #1;
      chk("R8 single pulse", {31'd0, rsp_valid}, 0);
   endtask

   initial begin
      #(8 * 150000);
      chk("watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_pin = '0; qry_pin = '0;
      mst_done = 1'b0; mst_nack = 1'b0;
      model[0] = 8'hFF; model[1] = 8'hFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 ready", {31'd0, cmd_ready}, 1);
      chk("R1 req", {31'd0, mst_req}, 0);
      chk("R1 rsp", {31'd0, rsp_valid}, 0);
      sweep();                                       // R1: all pins read 1

      drive(1'b0, 4'd15, 1'b0, 2, 1);                // R4 port 1 top bit
      drive(1'b0, 4'd7,  1'b1, 0, 0);                // R4 port 0, nack, zero latency
      drive(1'b1, 4'd0,  1'b0, 1, 1);                // R3 already set
      drive(1'b0, 4'd8,  1'b0, 3, 1);                // R2 port 1 bit 0
      drive(1'b1, 4'd15, 1'b1, 1, 0);                // R3 restore
      sweep();

      for (int k = 0; k < 60; k++) begin
         drive($urandom_range(0, 1) != 0, 4'($urandom_range(0, 15)),
               $urandom_range(0, 3) == 0, $urandom_range(0, 4), $urandom_range(0, 1) != 0);
         if (k % 20 == 19) sweep();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule